// File: doc/BRIEF.md
# EPP transfer gating controller

This block sits between a host register bus and a byte-wide peripheral transfer engine. It adds enhanced-parallel-port address and data transfers to an ordinary parallel-port register set. The host issues one access at a time, giving an offset, a direction, a byte count and write data. The block either answers from local state or runs one or more byte transfers over a request/done/error handshake. It signals completion with a one-cycle `ack`, and on reads it returns the assembled data on `rd_data`.

Transfers to the address and data ports start only when the stored control byte holds the right pattern for the direction. The data port accepts wider accesses and splits them into byte transfers, least significant byte first. A failed transfer raises a sticky timeout flag. That flag shows in bit 0 of every status read and stays set until the host writes a 1 to it. Writes to the data or control register that would not change the stored value produce no transfer.

Top module: `epp_gate`

## Requirements
- R1: After reset `busy`, `ack`, `per_req` and `timeout` are 0. A read of offset 2 returns 0xCC and a read of offset 0 returns 0xFF.
- R2: A write to offset 0 whose low byte differs from the stored data byte stores it and runs one transfer of kind 0 carrying that byte. A write of an equal byte stores it and runs no transfer. A read of offset 0 returns the stored byte.
- R3: A write to offset 2 stores the low byte with bits 7:6 forced to 1. If the forced value differs from the stored control byte, it runs one transfer of kind 1 carrying the forced value; otherwise it runs none. A read of offset 2 returns the stored control byte.
- R4: A write to offset 3 (kind 2) or offset 4 (kind 4) runs transfers only when control AND 0x2F equals 0x04. Otherwise it is acknowledged with no transfer.
- R5: A read of offset 3 (kind 3) or offset 4 (kind 5) runs transfers only when control AND 0x2F equals 0x24. Otherwise it returns all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF) with the upper bits zero.
- R6: At offset 4, `req_size` 1 means 2 bytes and 2 means 4 bytes; every other size, and every other offset, means 1 byte. The bytes move least significant first. Read bytes are placed at increasing byte lanes of `rd_data`.
- R7: A transfer ended by `per_err` sets `timeout`, skips the remaining bytes of the access and ends the access. Read lanes not filled by a successful byte return 0xFF.
- R8: A read of offset 1 returns `per_status[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R9: A write to offset 1 with bit 0 set clears the timeout flag. With bit 0 clear it has no effect on the flag.
- R10: `busy` is high from the cycle after a transfer-running access is accepted until its `ack`. A `req_valid` while `busy` is high is ignored.
- R11: A read of offsets 5 to 7 returns 0xFF with no transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access request, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_size | input | 2 | Byte count code for the data port |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access with transfers in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with `ack` |
| per_req | output | 1 | Byte transfer request |
| per_kind | output | 3 | Transfer kind 0 to 5 |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte from the peripheral, valid with `per_done` |
| per_done | input | 1 | Byte transfer succeeded |
| per_err | input | 1 | Byte transfer failed |
| per_status | input | 8 | Live peripheral status lines |
| timeout | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that the peripheral answers only while `per_req` is high and raises at most one of `per_done` and `per_err` per byte. They also assume it holds each pulse for a single cycle, so that one response consumes exactly one byte. The bench peripheral model releases its response at the falling edge after the rising edge that consumed it, and adds a random wait of zero to two cycles before each answer. The host driver holds `per_status` steady through each access. It raises `req_valid` for one cycle per access, apart from one deliberate request issued while `busy` is high.

// File: rtl/epp_gate.sv
module epp_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        ack,
  output logic [31:0] rd_data,
  output logic        per_req,
  output logic [2:0]  per_kind,
  output logic [7:0]  per_wdata,
  input  logic [7:0]  per_rdata,
  input  logic        per_done,
  input  logic        per_err,
  input  logic [7:0]  per_status,
  output logic        timeout
);
  localparam logic [7:0] SIG_MASK = 8'h2F;
  localparam logic [7:0] WR_PAT   = 8'h04;
  localparam logic [7:0] RD_PAT   = 8'h24;
  localparam logic [7:0] CTRL_RST = 8'hCC;
  localparam logic [2:0] K_DATA = 3'd0, K_CTRL = 3'd1, K_AW = 3'd2,
                         K_AR   = 3'd3, K_DW   = 3'd4, K_DR = 3'd5;

  logic [7:0]  ctrl_q, data_q;
  logic        tmo_q, xfer_q, ack_q;
  logic [1:0]  idx_q, last_q;
  logic [2:0]  kind_q;
  logic [31:0] wbuf_q, rbuf_q;

  wire       accept   = req_valid && !xfer_q;
  wire       wr_ok    = (ctrl_q & SIG_MASK) == WR_PAT;
  wire       rd_ok    = (ctrl_q & SIG_MASK) == RD_PAT;
  wire [7:0] wb       = req_wdata[7:0];
  wire [7:0] ctrl_new = wb | 8'hC0;
  wire [1:0] nlast    = (req_addr != 3'd4) ? 2'd0 :
                        (req_size == 2'd2) ? 2'd3 :
                        (req_size == 2'd1) ? 2'd1 : 2'd0;
  wire [31:0] ones    = (nlast == 2'd3) ? 32'hFFFF_FFFF :
                        (nlast == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;

  logic        start;
  logic [2:0]  kind_n;
  logic [31:0] imm;

  always_comb begin
    start  = 1'b0;
    kind_n = K_DATA;
    imm    = 32'h0;
    if (req_write) begin
      case (req_addr)
        3'd0: begin start = (wb != data_q);       kind_n = K_DATA; end
        3'd2: begin start = (ctrl_new != ctrl_q); kind_n = K_CTRL; end
        3'd3: begin start = wr_ok;                kind_n = K_AW;   end
        3'd4: begin start = wr_ok;                kind_n = K_DW;   end
        default: ;
      endcase
    end else begin
      case (req_addr)
        3'd0: imm = {24'h0, data_q};
        3'd1: imm = {24'h0, per_status[7:1], tmo_q};
        3'd2: imm = {24'h0, ctrl_q};
        3'd3: begin start = rd_ok; kind_n = K_AR; imm = ones; end
        3'd4: begin start = rd_ok; kind_n = K_DR; imm = ones; end
        default: imm = 32'h0000_00FF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      data_q <= 8'hFF;
      tmo_q  <= 1'b0;
      xfer_q <= 1'b0;
      ack_q  <= 1'b0;
      idx_q  <= 2'd0;
      last_q <= 2'd0;
      kind_q <= K_DATA;
      wbuf_q <= 32'h0;
      rbuf_q <= 32'h0;
    end else begin
      ack_q <= 1'b0;
      if (accept) begin
        if (req_write && req_addr == 3'd0) data_q <= wb;
        if (req_write && req_addr == 3'd2) ctrl_q <= ctrl_new;
        if (req_write && req_addr == 3'd1 && wb[0]) tmo_q <= 1'b0;
        kind_q <= kind_n;
        idx_q  <= 2'd0;
        last_q <= nlast;
        wbuf_q <= (req_addr == 3'd2) ? {24'h0, ctrl_new} : req_wdata;
        rbuf_q <= imm;
        xfer_q <= start;
        ack_q  <= !start;
      end else if (xfer_q && (per_done || per_err)) begin
        if (per_err) begin
          tmo_q  <= 1'b1;
          xfer_q <= 1'b0;
          ack_q  <= 1'b1;
        end else begin
          if (kind_q == K_AR || kind_q == K_DR) rbuf_q[idx_q*8 +: 8] <= per_rdata;
          if (idx_q == last_q) begin
            xfer_q <= 1'b0;
            ack_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
      end
    end
  end

  assign busy      = xfer_q;
  assign ack       = ack_q;
  assign rd_data   = rbuf_q;
  assign per_req   = xfer_q;
  assign per_kind  = kind_q;
  assign per_wdata = wbuf_q[idx_q*8 +: 8];
  assign timeout   = tmo_q;

  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && (per_kind == K_AW || per_kind == K_DW) |-> (ctrl_q & SIG_MASK) == WR_PAT);

  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && (per_kind == K_AR || per_kind == K_DR) |-> (ctrl_q & SIG_MASK) == RD_PAT);

  // R7
  err_sets_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && per_err |=> timeout && ack && !per_req);

  // R9
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !(req_valid && !busy && req_write && req_addr == 3'd1 && req_wdata[0])
    |=> timeout);

  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_done && !per_err |=> per_req && $stable(per_wdata) && $stable(per_kind));

  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);
endmodule

// File: tb/epp_gate_bench.sv
module epp_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = 32'h0;
  logic        busy, ack, per_req, timeout;
  logic [31:0] rd_data;
  logic [2:0]  per_kind;
  logic [7:0]  per_wdata;
  logic [7:0]  per_rdata = 8'h0;
  logic        per_done = 1'b0, per_err = 1'b0;
  logic [7:0]  per_status = 8'h0;

  epp_gate u_epp_gate (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int wait_cnt = 0, byte_no = 0, err_at = 9, nlog = 0, cyc = 0;
  logic [7:0] salt = 8'h0;
  logic [2:0] log_kind [0:7];
  logic [7:0] log_byte [0:7];
  logic [7:0] m_ctrl = 8'hCC, m_data = 8'hFF;
  logic       m_tmo = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (per_done || per_err) begin
      per_done = 1'b0;
      per_err  = 1'b0;
    end else if (per_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        if (nlog < 8) begin
          log_kind[nlog] = per_kind;
          log_byte[nlog] = per_wdata;
        end
        nlog++;
        per_rdata = salt + 8'(byte_no * 37);
        if (byte_no == err_at) per_err = 1'b1; else per_done = 1'b1;
        byte_no++;
        wait_cnt = $urandom % 3;
      end
    end
  end

  task automatic access(input bit w, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit intrude,
                        output logic [31:0] rd, output bit busy_ok);
    bit did = 0;
    busy_ok = 1;
    @(negedge clk);
    nlog = 0; byte_no = 0;
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!ack) begin
      if (!busy) busy_ok = 0;
      if (intrude && !did) begin
        req_valid = 1; req_write = 1; req_addr = 3'd0; req_wdata = 32'h5A; did = 1;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    rd = rd_data;
  endtask

  task automatic run_op(input bit w, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int err, input bit intrude);
    int nb, ncyc, ndone;
    logic [2:0] kind;
    logic [31:0] ew, erd, ones, rd;
    logic [7:0] v;
    bit busy_ok;
    string tag;
    nb = (a == 3'd4) ? (sz == 2'd2 ? 4 : sz == 2'd1 ? 2 : 1) : 1;
    ones = (nb == 4) ? 32'hFFFF_FFFF : (nb == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
    ncyc = 0; kind = 3'd0; ew = wd; erd = 32'h0; tag = "R2";
    salt = 8'($urandom);
    per_status = 8'($urandom);
    err_at = err;
    if (w) begin
      case (a)
        3'd0: begin tag = "R2"; if (wd[7:0] != m_data) begin ncyc = 1; kind = 0; end m_data = wd[7:0]; end
        3'd1: begin tag = "R9"; if (wd[0]) m_tmo = 0; end
        3'd2: begin tag = "R3"; v = wd[7:0] | 8'hC0;
                if (v != m_ctrl) begin ncyc = 1; kind = 1; ew = {24'h0, v}; end m_ctrl = v; end
        3'd3: begin tag = "R4"; if ((m_ctrl & 8'h2F) == 8'h04) begin ncyc = 1; kind = 2; end end
        3'd4: begin tag = "R4_R6"; if ((m_ctrl & 8'h2F) == 8'h04) begin ncyc = nb; kind = 4; end end
        default: tag = "R11";
      endcase
    end else begin
      case (a)
        3'd0: begin tag = "R2"; erd = {24'h0, m_data}; end
        3'd1: begin tag = "R8"; erd = {24'h0, per_status[7:1], m_tmo}; end
        3'd2: begin tag = "R3"; erd = {24'h0, m_ctrl}; end
        3'd3: begin tag = "R5"; erd = ones; if ((m_ctrl & 8'h2F) == 8'h24) begin ncyc = 1; kind = 3; end end
        3'd4: begin tag = "R5_R6"; erd = ones; if ((m_ctrl & 8'h2F) == 8'h24) begin ncyc = nb; kind = 5; end end
        default: begin tag = "R11"; erd = 32'hFF; end
      endcase
      for (int i = 0; i < ncyc; i++)
        if (i < err) erd[i*8 +: 8] = salt + 8'(i * 37);
    end
    ndone = (err < ncyc) ? err + 1 : ncyc;
    if (err < ncyc) begin m_tmo = 1; tag = {tag, "_R7"}; end
    access(w, a, sz, wd, intrude, rd, busy_ok);
    chk(nlog == ndone, {tag, " transfer count"}, nlog, ndone);
    for (int i = 0; i < ndone && i < nlog && i < 8; i++) begin
      chk(log_kind[i] == kind, {tag, " kind"}, {29'h0, log_kind[i]}, {29'h0, kind});
      if (w) chk(log_byte[i] == ew[i*8 +: 8], {tag, " byte order"}, {24'h0, log_byte[i]}, {24'h0, ew[i*8 +: 8]});
    end
    if (!w) chk(rd == erd, {tag, " read data"}, rd, erd);
    chk(timeout == m_tmo, {tag, " R7 R9 timeout flag"}, {31'h0, timeout}, {31'h0, m_tmo});
    if (ncyc > 0) chk(busy_ok, "R10 busy during transfer", {31'h0, busy_ok}, 32'h1);
  endtask

  initial begin
    int a, sz, err, wsel;
    logic [31:0] wd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !ack && !per_req && !timeout, "R1 reset outputs",
        {28'h0, busy, ack, per_req, timeout}, 32'h0);
    rst_n = 1'b1;
    run_op(0, 3'd2, 0, 0, 9, 0);            // R1 control reset value
    run_op(0, 3'd0, 0, 0, 9, 0);            // R1 data reset value
    run_op(1, 3'd4, 2, 32'h11223344, 9, 0); // R4 gated off at reset
    run_op(0, 3'd4, 2, 0, 9, 0);            // R5 all ones at 4 bytes
    run_op(1, 3'd2, 0, 32'h04, 9, 0);       // R3 forced bits
    run_op(1, 3'd2, 0, 32'hC4, 9, 0);       // R3 redundant after forcing
    run_op(1, 3'd4, 2, 32'hA1B2C3D4, 9, 0); // R6 four bytes LSB first
    run_op(1, 3'd4, 1, 32'h0000BEEF, 9, 0); // R6 two bytes
    run_op(1, 3'd3, 2, 32'h77, 9, 0);       // R6 size ignored at offset 3
    run_op(0, 3'd4, 1, 0, 9, 0);            // R5 mismatch two bytes ones
    run_op(1, 3'd4, 2, 32'h55667788, 2, 0); // R7 error on third byte
    run_op(0, 3'd1, 0, 0, 9, 0);            // R8 status shows timeout
    run_op(1, 3'd1, 0, 32'hFE, 9, 0);       // R9 bit0 clear keeps flag
    run_op(1, 3'd1, 0, 32'h01, 9, 0);       // R9 clear
    run_op(1, 3'd0, 0, 32'h12, 9, 0);       // R2 data change
    run_op(1, 3'd0, 0, 32'h12, 9, 0);       // R2 redundant data
    run_op(1, 3'd4, 2, 32'hCAFEF00D, 9, 1); // R10 request while busy ignored
    run_op(0, 3'd0, 0, 0, 9, 0);            // R10 data still 0x12
    run_op(1, 3'd2, 0, 32'h24, 9, 0);
    run_op(0, 3'd4, 2, 0, 9, 0);            // R6 four-byte read
    run_op(0, 3'd4, 2, 0, 1, 0);            // R7 read error on second byte
    run_op(0, 3'd3, 0, 0, 0, 0);            // R7 error on first byte
    run_op(0, 3'd6, 0, 0, 9, 0);            // R11
    for (int k = 0; k < 400; k++) begin
      a = $urandom % 8;
      if ($urandom % 3 != 0) a = 3 + ($urandom % 2);
      sz = $urandom % 4;
      err = ($urandom % 4 == 0) ? ($urandom % 4) : 9;
      wsel = $urandom % 4;
      wd = $urandom;
      if (a == 2) wd[7:0] = (wsel == 0) ? 8'h04 : (wsel == 1) ? 8'h24 : (wsel == 2) ? 8'hCC : wd[7:0];
      if (a == 0 && wsel == 0) wd[7:0] = m_data;
      run_op(($urandom % 2) == 1, 3'(a), 2'(sz), wd, err, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule